// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block watches the control and address pins of a four-bank single-data-rate SDRAM interface on every rising clock edge. It decodes the command driven that cycle and keeps its own model of the device and of each bank. The model covers open rows, write recovery with and without auto precharge, precharge, refresh, mode-register programming, power-down and self refresh. A command that the current state does not allow, or that arrives before a minimum spacing has elapsed, is flagged.

The monitor is placed next to a memory controller in simulation or in silicon debug logic. It never drives the memory. Every spacing limit is a cycle-count parameter. After each edge the outputs give the decoded command, a one-cycle violation flag with a reason code, and the state of the device and of every bank. A state is shown as the state that the next command will be judged against, so a timed phase that has run out already shows its successor.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: The command sampled at an edge is decoded from {sel_n,row_n,col_n,wr_n} and shown on cmd_o after that edge. sel_n high gives DESL=0. Otherwise 111 gives NOP=1, 110 BST=2, 101 READ=3, 100 WRITE=4, 011 ACT=5, 010 PRE=6, 001 REF=7 and 000 MRS=8.
- R2: While rst_n is low, dev_state_o is NORMAL=0, every bank field is IDLE=0, illegal_o is 0 and reason_o is 0. The clock enable is taken as high.
- R3: Bank field b is bank_state_o[3b+2:3b], with codes IDLE=0, ACTIVE=1, WREC=2, WREC_AP=3 and PRECHG=4. ACT is legal only on an IDLE bank. READ and WRITE are legal only on an ACTIVE or WREC bank. A violation is judged against the addressed bank alone and gives reason STATE=1.
- R4: WRITE with ap_all low puts the bank in WREC, and the bank shows ACTIVE once T_WR cycles have passed. In WREC, READ or WRITE is legal, while PRE, PALL, REF and MRS are flagged with reason 1.
- R5: WRITE with ap_all high puts the bank in WREC_AP. After T_WR cycles it shows PRECHG and then IDLE T_RP cycles later. Any READ or WRITE to that bank meanwhile is flagged with reason 1.
- R6: REF with all banks IDLE gives dev_state_o REFRESH=1 for T_RC cycles and then NORMAL. While refresh is running only DESL, NOP and BST are legal. REF while any bank is not IDLE is flagged with reason 1.
- R7: MRS with all banks IDLE gives dev_state_o MODE=2 for T_MRD cycles. Only DESL and NOP are legal during that time, and BST is flagged with reason 1.
- R8: READ or WRITE fewer than T_RCD cycles after ACT to the same bank is flagged with reason RCD=2.
- R9: PRE or PALL that would close a bank opened fewer than T_RAS cycles earlier is flagged with reason RAS=3. Once the spacing is met, PRE gives PRECHG and the bank is IDLE T_RP cycles later.
- R10: ACT fewer than T_RRD cycles after the previous accepted ACT is flagged with reason RRD=4.
- R11: If clk_en falls while all banks are IDLE and the device is NORMAL, a REF gives SELFREF=4 and a DESL or NOP gives PWRDN=3. While clk_en stays low, commands are ignored. If clk_en rises in PWRDN the device returns to NORMAL, and if it rises in SELFREF the device enters REFRESH. A fall of clk_en in any other case is flagged with reason CKE=5.
- R12: illegal_o is high for exactly the cycle after the offending edge, and reason_o is 0 whenever illegal_o is low. A flagged command changes no state, although running timers keep counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Chip select, active low |
| row_n | input | 1 | Row strobe, active low |
| col_n | input | 1 | Column strobe, active low |
| wr_n | input | 1 | Write enable, active low |
| clk_en | input | 1 | Memory clock enable |
| bank_sel | input | BA_W | Bank address |
| ap_all | input | 1 | Auto precharge on READ/WRITE, all banks on PRE |
| cmd_o | output | 4 | Decoded command of the last edge |
| dev_state_o | output | 3 | Device state |
| bank_state_o | output | 3*2**BA_W | Per-bank state fields |
| illegal_o | output | 1 | Violation flag, one cycle |
| reason_o | output | 3 | Violation reason code |

## Verification
A wrong internal state shows on the ports in two ways. It appears at once in dev_state_o or bank_state_o after the edge that caused it, or it shows up later as a wrong verdict on the next command that touches the affected bank. For that reason the sequences check state after each step and also probe each timed phase with a command exactly one cycle before its limit and another exactly at the limit. An off-by-one timer therefore flips either a verdict or a state code within the cycle where the limit falls.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
  typedef enum logic [3:0] {
    C_DESL = 4'd0, C_NOP = 4'd1, C_BST = 4'd2, C_READ = 4'd3, C_WRITE = 4'd4,
    C_ACT = 4'd5, C_PRE = 4'd6, C_REF = 4'd7, C_MRS = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    B_IDLE = 3'd0, B_ACTIVE = 3'd1, B_WREC = 3'd2, B_WREC_AP = 3'd3, B_PRECHG = 3'd4
  } bank_e;

  typedef enum logic [2:0] {
    D_NORMAL = 3'd0, D_REFRESH = 3'd1, D_MODE = 3'd2, D_PWRDN = 3'd3, D_SELFREF = 3'd4
  } dev_e;

  typedef enum logic [2:0] {
    W_NONE = 3'd0, W_STATE = 3'd1, W_RCD = 3'd2, W_RAS = 3'd3, W_RRD = 3'd4, W_CKE = 3'd5
  } why_e;

  localparam int unsigned STATE_W = 3;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic sel_n,
  input  logic row_n,
  input  logic col_n,
  input  logic wr_n,
  output cmd_e cmd_o
);
  always_comb begin
    if (sel_n) begin
      cmd_o = C_DESL;
    end else begin
      case ({row_n, col_n, wr_n})
        3'b111:  cmd_o = C_NOP;
        3'b110:  cmd_o = C_BST;
        3'b101:  cmd_o = C_READ;
        3'b100:  cmd_o = C_WRITE;
        3'b011:  cmd_o = C_ACT;
        3'b010:  cmd_o = C_PRE;
        3'b001:  cmd_o = C_REF;
        default: cmd_o = C_MRS;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int unsigned T_WR  = 2,
  parameter int unsigned T_RP  = 2,
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_RAS = 5,
  parameter int unsigned CW    = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  act_i,
  input  logic  rd_i,
  input  logic  wr_i,
  input  logic  pre_i,
  input  logic  ap_i,
  output bank_e state_o,
  output logic  rcd_ok_o,
  output logic  ras_ok_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  bank_e st_q, st_d, eff;
  logic [CW-1:0] cnt_q, cnt_d, rcd_q, rcd_d, ras_q, ras_d;

  // state the next command is judged against: an expired timed phase shows its successor
  always_comb begin
    eff = st_q;
    if (cnt_q == '0) begin
      case (st_q)
        B_WREC:    eff = B_ACTIVE;
        B_WREC_AP: eff = B_PRECHG;
        B_PRECHG:  eff = B_IDLE;
        default:   eff = st_q;
      endcase
    end
  end

  always_comb begin
    st_d  = eff;
    cnt_d = (cnt_q != '0) ? cnt_q - ONE : '0;
    rcd_d = (rcd_q != '0) ? rcd_q - ONE : '0;
    ras_d = (ras_q != '0) ? ras_q - ONE : '0;
    if (st_q == B_WREC_AP && cnt_q == '0) cnt_d = CW'(T_RP - 1);
    if (act_i) begin
      st_d  = B_ACTIVE;
      rcd_d = CW'(T_RCD - 1);
      ras_d = CW'(T_RAS - 1);
    end
    if (rd_i) begin
      if (ap_i) begin
        st_d  = B_PRECHG;
        cnt_d = CW'(T_RP - 1);
      end else begin
        st_d = B_ACTIVE;
      end
    end
    if (wr_i) begin
      st_d  = ap_i ? B_WREC_AP : B_WREC;
      cnt_d = CW'(T_WR - 1);
    end
    if (pre_i) begin
      st_d  = B_PRECHG;
      cnt_d = CW'(T_RP - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= B_IDLE;
      cnt_q <= '0;
      rcd_q <= '0;
      ras_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rcd_q <= rcd_d;
      ras_q <= ras_d;
    end
  end

  assign state_o  = eff;
  assign rcd_ok_o = (rcd_q == '0);
  assign ras_ok_o = (ras_q == '0);
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int unsigned BA_W  = 2,
  parameter int unsigned T_WR  = 2,
  parameter int unsigned T_RC  = 7,
  parameter int unsigned T_MRD = 2,
  parameter int unsigned T_RCD = 2,
  parameter int unsigned T_RAS = 5,
  parameter int unsigned T_RRD = 2,
  parameter int unsigned T_RP  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel_n,
  input  logic                       row_n,
  input  logic                       col_n,
  input  logic                       wr_n,
  input  logic                       clk_en,
  input  logic [BA_W-1:0]            bank_sel,
  input  logic                       ap_all,
  output logic [3:0]                 cmd_o,
  output logic [2:0]                 dev_state_o,
  output logic [(2**BA_W)*3-1:0]     bank_state_o,
  output logic                       illegal_o,
  output logic [2:0]                 reason_o
);
  localparam int unsigned NB   = 2 ** BA_W;
  localparam int unsigned TMAX = max2(max2(max2(T_WR, T_RC), max2(T_MRD, T_RCD)),
                                      max2(max2(T_RAS, T_RRD), T_RP));
  localparam int unsigned CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] ONE = CW'(1);

  cmd_e          cmd, cmd_q;
  dev_e          dev_q, dev_d, dev_eff;
  why_e          why, why_q;
  logic          ill, ill_q, cke_q;
  logic [CW-1:0] dcnt_q, dcnt_d, rrd_q, rrd_d;
  bank_e         beff [NB];
  bank_e         tgt;
  logic [NB-1:0] rcd_ok, ras_ok, act_v, rd_v, wr_v, pre_v;
  logic          all_idle, any_wrec, ras_block;

  sdram_cmd_decode u_dec (
    .sel_n(sel_n), .row_n(row_n), .col_n(col_n), .wr_n(wr_n), .cmd_o(cmd)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdram_bank_track #(
      .T_WR(T_WR), .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS), .CW(CW)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .act_i(act_v[g]), .rd_i(rd_v[g]), .wr_i(wr_v[g]), .pre_i(pre_v[g]), .ap_i(ap_all),
      .state_o(beff[g]), .rcd_ok_o(rcd_ok[g]), .ras_ok_o(ras_ok[g])
    );
    assign bank_state_o[g*STATE_W +: STATE_W] = beff[g];
  end

  assign tgt = beff[bank_sel];

  always_comb begin
    all_idle  = 1'b1;
    any_wrec  = 1'b0;
    ras_block = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (beff[i] != B_IDLE) all_idle = 1'b0;
      if (beff[i] == B_WREC || beff[i] == B_WREC_AP) any_wrec = 1'b1;
      if (beff[i] == B_ACTIVE && !ras_ok[i]) ras_block = 1'b1;
    end
  end

  always_comb begin
    dev_eff = dev_q;
    if ((dev_q == D_REFRESH || dev_q == D_MODE) && dcnt_q == '0) dev_eff = D_NORMAL;
  end

  // command legality against the state table
  always_comb begin
    ill    = 1'b0;
    why    = W_NONE;
    act_v  = '0;
    rd_v   = '0;
    wr_v   = '0;
    pre_v  = '0;
    dev_d  = dev_eff;
    dcnt_d = (dcnt_q != '0) ? dcnt_q - ONE : '0;
    rrd_d  = (rrd_q != '0) ? rrd_q - ONE : '0;
    if (!cke_q) begin
      if (clk_en) begin
        if (dev_q == D_PWRDN) begin
          dev_d = D_NORMAL;
        end else if (dev_q == D_SELFREF) begin
          dev_d  = D_REFRESH;
          dcnt_d = CW'(T_RC - 1);
        end
      end
    end else if (!clk_en) begin
      if (dev_eff == D_NORMAL && all_idle && cmd == C_REF) begin
        dev_d = D_SELFREF;
      end else if (dev_eff == D_NORMAL && all_idle && (cmd == C_DESL || cmd == C_NOP)) begin
        dev_d = D_PWRDN;
      end else begin
        ill = 1'b1;
        why = W_CKE;
      end
    end else begin
      case (dev_eff)
        D_REFRESH: begin
          if (!(cmd == C_DESL || cmd == C_NOP || cmd == C_BST)) begin
            ill = 1'b1;
            why = W_STATE;
          end
        end
        D_MODE: begin
          if (!(cmd == C_DESL || cmd == C_NOP)) begin
            ill = 1'b1;
            why = W_STATE;
          end
        end
        default: begin
          case (cmd)
            C_ACT: begin
              if (tgt != B_IDLE) begin
                ill = 1'b1; why = W_STATE;
              end else if (rrd_q != '0) begin
                ill = 1'b1; why = W_RRD;
              end else begin
                act_v[bank_sel] = 1'b1;
                rrd_d = CW'(T_RRD - 1);
              end
            end
            C_READ, C_WRITE: begin
              if (!(tgt == B_ACTIVE || tgt == B_WREC)) begin
                ill = 1'b1; why = W_STATE;
              end else if (!rcd_ok[bank_sel]) begin
                ill = 1'b1; why = W_RCD;
              end else if (cmd == C_READ) begin
                rd_v[bank_sel] = 1'b1;
              end else begin
                wr_v[bank_sel] = 1'b1;
              end
            end
            C_PRE: begin
              if (ap_all) begin
                if (any_wrec) begin
                  ill = 1'b1; why = W_STATE;
                end else if (ras_block) begin
                  ill = 1'b1; why = W_RAS;
                end else begin
                  for (int i = 0; i < NB; i++) pre_v[i] = (beff[i] == B_ACTIVE);
                end
              end else begin
                if (tgt == B_WREC || tgt == B_WREC_AP) begin
                  ill = 1'b1; why = W_STATE;
                end else if (tgt == B_ACTIVE && !ras_ok[bank_sel]) begin
                  ill = 1'b1; why = W_RAS;
                end else if (tgt == B_ACTIVE) begin
                  pre_v[bank_sel] = 1'b1;
                end
              end
            end
            C_REF: begin
              if (!all_idle) begin
                ill = 1'b1; why = W_STATE;
              end else begin
                dev_d  = D_REFRESH;
                dcnt_d = CW'(T_RC - 1);
              end
            end
            C_MRS: begin
              if (!all_idle) begin
                ill = 1'b1; why = W_STATE;
              end else begin
                dev_d  = D_MODE;
                dcnt_d = CW'(T_MRD - 1);
              end
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q  <= 1'b1;
      dev_q  <= D_NORMAL;
      dcnt_q <= '0;
      rrd_q  <= '0;
      cmd_q  <= C_DESL;
      ill_q  <= 1'b0;
      why_q  <= W_NONE;
    end else begin
      cke_q  <= clk_en;
      dev_q  <= dev_d;
      dcnt_q <= dcnt_d;
      rrd_q  <= rrd_d;
      cmd_q  <= cmd;
      ill_q  <= ill;
      why_q  <= why;
    end
  end

  assign cmd_o       = cmd_q;
  assign dev_state_o = dev_eff;
  assign illegal_o   = ill_q;
  assign reason_o    = why_q;
endmodule

// File: rtl/sdram_mon_checker.sv
module sdram_mon_checker #(
  parameter int unsigned BA_W  = 2,
  parameter int unsigned T_RRD = 2,
  parameter int unsigned T_RC  = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sel_n,
  input logic                   row_n,
  input logic                   col_n,
  input logic                   wr_n,
  input logic                   clk_en,
  input logic [BA_W-1:0]        bank_sel,
  input logic [3:0]             cmd_o,
  input logic [2:0]             dev_state_o,
  input logic [(2**BA_W)*3-1:0] bank_state_o,
  input logic                   illegal_o,
  input logic [2:0]             reason_o
);
  logic act_pins, read_pins;
  assign act_pins  = !sel_n && !row_n && col_n && wr_n;
  assign read_pins = !sel_n && row_n && !col_n && wr_n;

  // R12: a reason is carried exactly when the flag is raised
  p_reason_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (reason_o != 3'd0 && reason_o <= 3'd5));
  p_reason_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal_o |-> reason_o == 3'd0);

  // R3: READ to an idle bank is refused for state
  p_read_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (read_pins && clk_en && $past(clk_en) && dev_state_o == 3'd0 &&
     bank_state_o[bank_sel*3 +: 3] == 3'd0) |=> (illegal_o && reason_o == 3'd1));

  // R6: no ACT while refresh runs
  p_refresh_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_pins && clk_en && $past(clk_en) && dev_state_o == 3'd1) |=> (illegal_o && reason_o == 3'd1));

  // R11: leaving power-down
  p_pwrdn_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_state_o == 3'd3 && clk_en) |=> dev_state_o == 3'd0);

  if (T_RC >= 2) begin : g_sr
    // R11: leaving self refresh enters refresh
    p_selfref_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_state_o == 3'd4 && clk_en) |=> dev_state_o == 3'd1);
  end

  if (T_RRD >= 2) begin : g_rrd
    // R10: two accepted ACTs never land on adjacent edges
    p_act_spacing_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 4'd5 && !illegal_o && act_pins && clk_en && $past(clk_en) &&
       dev_state_o == 3'd0) |=> illegal_o);
  end
endmodule

bind sdram_cmd_monitor sdram_mon_checker #(
  .BA_W(BA_W), .T_RRD(T_RRD), .T_RC(T_RC)
) u_mon_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .row_n(row_n), .col_n(col_n), .wr_n(wr_n),
  .clk_en(clk_en), .bank_sel(bank_sel), .cmd_o(cmd_o), .dev_state_o(dev_state_o),
  .bank_state_o(bank_state_o), .illegal_o(illegal_o), .reason_o(reason_o)
);

// File: tb/test_sdram_cmd_monitor.sv
`timescale 1ns/1ps
module test_sdram_cmd_monitor;
  localparam logic [3:0] P_DESL = 4'b1111, P_NOP = 4'b0111, P_BST = 4'b0110,
                         P_RD = 4'b0101, P_WR = 4'b0100, P_ACT = 4'b0011,
                         P_PRE = 4'b0010, P_REF = 4'b0001, P_MRS = 4'b0000;

  logic        clk, rst_n, sel_n, row_n, col_n, wr_n, clk_en, ap_all;
  logic [1:0]  bank_sel;
  logic [3:0]  cmd_o;
  logic [2:0]  dev_state_o, reason_o;
  logic [11:0] bank_state_o;
  logic        illegal_o;
  int          checks, errors;
  bit          done;

  sdram_cmd_monitor i_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .row_n(row_n), .col_n(col_n), .wr_n(wr_n),
    .clk_en(clk_en), .bank_sel(bank_sel), .ap_all(ap_all), .cmd_o(cmd_o),
    .dev_state_o(dev_state_o), .bank_state_o(bank_state_o), .illegal_o(illegal_o),
    .reason_o(reason_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bs(input int b);
    return int'(bank_state_o[b*3 +: 3]);
  endfunction

  // drive at a falling edge, return at the next falling edge with the result visible
  task automatic issue(input logic [3:0] p, input int b, input logic a, input logic ck);
    {sel_n, row_n, col_n, wr_n} = p;
    bank_sel = 2'(b);
    ap_all   = a;
    clk_en   = ck;
    @(negedge clk);
  endtask

  task automatic verdict(input string req, input int ill, input int why);
    chk(req, int'(illegal_o), ill);
    chk(req, int'(reason_o), why);
  endtask

  initial begin
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0;
    {sel_n, row_n, col_n, wr_n} = P_DESL;
    bank_sel = 2'd0; ap_all = 1'b0; clk_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 dev", int'(dev_state_o), 0);
    chk("R2 banks", int'(bank_state_o), 0);
    verdict("R2 flag", 0, 0);
    rst_n = 1'b1;

    // R1: every pin combination, expected code computed from the pins
    for (int p = 0; p < 16; p++) begin
      int exp_c;
      exp_c = (p >= 8) ? 0 : 8 - (p % 8);
      issue(4'(p), 0, 1'b0, 1'b1);
      chk("R1 decode", int'(cmd_o), exp_c);
      repeat (10) issue(P_NOP, 0, 1'b0, 1'b1);
      issue(P_PRE, 0, 1'b1, 1'b1);
      repeat (3) issue(P_NOP, 0, 1'b0, 1'b1);
    end

    // R3 and R12
    issue(P_ACT, 1, 1'b0, 1'b1);
    chk("R3 open", bs(1), 1);
    verdict("R3 act ok", 0, 0);
    repeat (2) issue(P_NOP, 0, 1'b0, 1'b1);
    issue(P_ACT, 1, 1'b0, 1'b1);
    verdict("R3 act on open", 1, 1);
    chk("R12 unchanged", bs(1), 1);
    issue(P_NOP, 0, 1'b0, 1'b1);
    verdict("R12 pulse ends", 0, 0);
    issue(P_RD, 2, 1'b0, 1'b1);
    verdict("R3 read idle", 1, 1);
    chk("R3 target", bs(2), 0);
    chk("R3 other bank", bs(1), 1);

    // R8
    issue(P_ACT, 0, 1'b0, 1'b1);
    verdict("R8 act", 0, 0);
    issue(P_RD, 0, 1'b0, 1'b1);
    verdict("R8 early read", 1, 2);
    issue(P_RD, 0, 1'b0, 1'b1);
    verdict("R8 read at limit", 0, 0);

    // R9: ACT was three edges ago, limit is five
    issue(P_PRE, 0, 1'b0, 1'b1);
    verdict("R9 early pre", 1, 3);
    chk("R9 still open", bs(0), 1);
    issue(P_NOP, 0, 1'b0, 1'b1);
    issue(P_PRE, 0, 1'b0, 1'b1);
    verdict("R9 pre at limit", 0, 0);
    chk("R9 precharging", bs(0), 4);
    issue(P_NOP, 0, 1'b0, 1'b1);
    chk("R9 idle after rp", bs(0), 0);

    // R10
    issue(P_ACT, 2, 1'b0, 1'b1);
    verdict("R10 first act", 0, 0);
    issue(P_ACT, 3, 1'b0, 1'b1);
    verdict("R10 close act", 1, 4);
    chk("R10 not opened", bs(3), 0);
    issue(P_ACT, 3, 1'b0, 1'b1);
    verdict("R10 act at limit", 0, 0);
    chk("R10 opened", bs(3), 1);

    // R4
    issue(P_NOP, 0, 1'b0, 1'b1);
    issue(P_WR, 2, 1'b0, 1'b1);
    verdict("R4 write", 0, 0);
    chk("R4 recovering", bs(2), 2);
    issue(P_PRE, 2, 1'b0, 1'b1);
    verdict("R4 pre in recovery", 1, 1);
    chk("R4 back to active", bs(2), 1);
    issue(P_WR, 2, 1'b0, 1'b1);
    chk("R4 recovering again", bs(2), 2);
    issue(P_RD, 2, 1'b0, 1'b1);
    verdict("R4 read in recovery", 0, 0);
    chk("R4 read leaves active", bs(2), 1);

    // R5
    issue(P_WR, 3, 1'b1, 1'b1);
    verdict("R5 write ap", 0, 0);
    chk("R5 recovering ap", bs(3), 3);
    issue(P_RD, 3, 1'b0, 1'b1);
    verdict("R5 read refused", 1, 1);
    chk("R5 precharging", bs(3), 4);
    issue(P_NOP, 0, 1'b0, 1'b1);
    chk("R5 still precharging", bs(3), 4);
    issue(P_NOP, 0, 1'b0, 1'b1);
    chk("R5 idle", bs(3), 0);

    // R6
    issue(P_REF, 0, 1'b0, 1'b1);
    verdict("R6 ref with open rows", 1, 1);
    issue(P_PRE, 0, 1'b1, 1'b1);
    verdict("R6 pall", 0, 0);
    chk("R6 pall bank1", bs(1), 4);
    chk("R6 pall bank2", bs(2), 4);
    issue(P_NOP, 0, 1'b0, 1'b1);
    chk("R6 all idle", int'(bank_state_o), 0);
    issue(P_REF, 0, 1'b0, 1'b1);
    chk("R6 refreshing", int'(dev_state_o), 1);
    issue(P_ACT, 0, 1'b0, 1'b1);
    verdict("R6 act in refresh", 1, 1);
    issue(P_BST, 0, 1'b0, 1'b1);
    verdict("R6 bst in refresh", 0, 0);
    repeat (3) issue(P_NOP, 0, 1'b0, 1'b1);
    chk("R6 refresh before limit", int'(dev_state_o), 1);
    issue(P_NOP, 0, 1'b0, 1'b1);
    chk("R6 refresh done", int'(dev_state_o), 0);

    // R7
    issue(P_MRS, 0, 1'b0, 1'b1);
    chk("R7 mode", int'(dev_state_o), 2);
    issue(P_BST, 0, 1'b0, 1'b1);
    verdict("R7 bst refused", 1, 1);
    chk("R7 mode done", int'(dev_state_o), 0);

    // R11
    issue(P_NOP, 0, 1'b0, 1'b0);
    verdict("R11 pd entry", 0, 0);
    chk("R11 powered down", int'(dev_state_o), 3);
    issue(P_RD, 0, 1'b0, 1'b0);
    verdict("R11 ignored", 0, 0);
    chk("R11 still down", int'(dev_state_o), 3);
    issue(P_NOP, 0, 1'b0, 1'b1);
    chk("R11 pd exit", int'(dev_state_o), 0);
    issue(P_REF, 0, 1'b0, 1'b0);
    chk("R11 self refresh", int'(dev_state_o), 4);
    issue(P_NOP, 0, 1'b0, 1'b0);
    chk("R11 stays self refresh", int'(dev_state_o), 4);
    issue(P_NOP, 0, 1'b0, 1'b1);
    chk("R11 sr exit refresh", int'(dev_state_o), 1);
    repeat (6) issue(P_NOP, 0, 1'b0, 1'b1);
    chk("R11 sr exit done", int'(dev_state_o), 0);
    issue(P_ACT, 0, 1'b0, 1'b1);
    verdict("R11 act", 0, 0);
    issue(P_NOP, 0, 1'b0, 1'b0);
    verdict("R11 cke misuse", 1, 5);
    chk("R11 misuse keeps device", int'(dev_state_o), 0);
    chk("R11 misuse keeps bank", bs(0), 1);
    issue(P_NOP, 0, 1'b0, 1'b1);
    verdict("R12 after misuse", 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual not finished, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule